// File: doc/BRIEF.md
# Low-Power-Domain Reset Controller Register Bank

This block is the software-visible register bank of a low-power-domain reset controller. A host reaches it through a simple single-cycle register bus. Each access is a full 32-bit word, with valid, write, byte address, write data and read data. Behind the bus sit three things. The first is a one-bit interrupt group: a status flag, a mask, and write-one aliases that enable or disable the interrupt. The second is a core reset register that drives two processor cores. The third is a row of peripheral reset registers. A handful of clock-control words sit beside these as plain storage with reset values and reserved bits.

The reset registers act on changes, not on writes. When a core reset bit goes from 0 to 1, the block emits a one-cycle power-off request for that core. When it goes from 1 to 0, the block emits a one-cycle release-with-reset request. A peripheral reset bit that changes in either direction gives a one-cycle cold-reset pulse to that peripheral. This applies to the five linked peripherals: two UARTs, two Ethernet MACs and USB. A single DMA bit fans out to every DMA channel. Each reset bit is also brought out as a level. Peripherals and cores come out of reset held in reset, and the interrupt starts masked.

Address map (byte offsets): 0x00 status, 0x04 mask, 0x08 enable alias, 0x0C disable alias, 0x10 to 0x24 six clock-control words, 0x40 core reset. The peripheral resets follow at 0x44 + 4*i with i = 0 UART0, 1 UART1, 2 MAC0, 3 MAC1, 4 USB, 5 DMA, 6 SPI0, 7 SPI1, 8 CAN0, 9 CAN1, 10 I2C0, 11 I2C1, 12 GPIO, 13 timestamp, 14 watchdog.

Top module: `lpd_rstctl_regs`

## Requirements
- R1: After reset the registers hold these values: status reads 0, mask reads 1, the core word reads 0x17, every peripheral word reads 1, and clock words 0..5 read 0x02000300, 0x02000800, 0x02000A00, 0x00000C00, 0x00000600 and 0x02000C00. `irq_o` is low, all level reset outputs are high and every request and pulse output is low.
- R2: `irq_o` is high exactly when status bit 0 is 1 and mask bit 0 is 0.
- R3: A high `irq_src` at a clock edge sets status bit 0. Writing 1 to bit 0 at 0x00 clears it, and writing 0 there has no effect. When a set and a clear meet in the same cycle, the set wins.
- R4: Writes to the mask at 0x04 are ignored. Writing bit 0 = 1 to 0x08 clears the mask and writing bit 0 = 1 to 0x0C sets it. A 0 in bit 0 of either alias has no effect. Both aliases read 0.
- R5: In the core word, bit 0 controls core 0 and bit 1 controls core 1. Only bits 0, 1, 2 and 4 are writable, and all other bits read 0. A 0-to-1 change of a core bit pulses `core_off_req` for one cycle, and a 1-to-0 change pulses `core_on_req` for one cycle. An unchanged bit pulses nothing. `core_rst` follows bits 1:0.
- R6: Bit 0 of each peripheral word drives `per_rst[i]`. A change of bit 0 for i = 0..4, in either direction, pulses `per_cold_rst[i]` for one cycle. Rewriting the same value does not pulse, and the words with i = 6..14 have no pulse output.
- R7: The DMA word (i = 5, 0x58) drives every bit of `dma_rst`. A change of its bit pulses every bit of `dma_cold_rst` together for one cycle.
- R8: The clock words are plain storage with the writable mask 0x0203FF07. Other bits read 0.
- R9: An access to an unmapped word index, or to an address with bits 1:0 not zero, reads 0 and changes no register.
- R10: A write takes effect at the clock edge where `bus_valid` and `bus_write` are high. The resulting pulses are high during the following cycle. Read data is combinational while `bus_valid` is high and `bus_write` is low, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| irq_src | input | 1 | Event that sets status bit 0 |
| irq_o | output | 1 | Interrupt line |
| core_rst | output | 2 | Core reset levels |
| core_off_req | output | 2 | One-cycle core power-off requests |
| core_on_req | output | 2 | One-cycle core release-with-reset requests |
| per_rst | output | 15 | Peripheral reset levels |
| per_cold_rst | output | 5 | One-cycle cold-reset pulses for UART0, UART1, MAC0, MAC1, USB |
| dma_rst | output | N_DMA | DMA channel reset levels |
| dma_cold_rst | output | N_DMA | DMA channel cold-reset pulses |

## Verification
The assertions assume the bus carries one access per cycle. They also assume that `irq_src` and a status clear may coincide but never carry meaning outside a clock edge. The pulse checks compare each request against the level it came from one cycle earlier, so they rely on the reset levels being known from the first edge after reset. The stimulus drives every input on the falling edge, holds each access for exactly one rising edge, and samples outputs on the next falling edge, so each access lands in a single known cycle.

// File: rtl/lpd_rstctl_regs.sv
module lpd_rstctl_regs #(
  parameter int ADDR_W = 8,
  parameter int N_DMA  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              irq_src,
  output logic              irq_o,
  output logic [1:0]        core_rst,
  output logic [1:0]        core_off_req,
  output logic [1:0]        core_on_req,
  output logic [14:0]       per_rst,
  output logic [4:0]        per_cold_rst,
  output logic [N_DMA-1:0]  dma_rst,
  output logic [N_DMA-1:0]  dma_cold_rst
);

  localparam int IW        = ADDR_W - 2;
  localparam int IX_STAT   = 0;
  localparam int IX_MASK   = 1;
  localparam int IX_EN     = 2;
  localparam int IX_DIS    = 3;
  localparam int CLK_BASE  = 4;
  localparam int N_CLK     = 6;
  localparam int IX_CORE   = 16;
  localparam int PER_BASE  = 17;
  localparam int N_PER     = 15;
  localparam int N_LINK    = 5;
  localparam int DMA_IX    = 5;
  localparam logic [4:0]  CORE_WMASK = 5'h17;
  localparam logic [31:0] CLK_WMASK  = 32'h0203_FF07;
  localparam logic [31:0] CLK_INIT [N_CLK] = '{
    32'h0200_0300, 32'h0200_0800, 32'h0200_0A00,
    32'h0000_0C00, 32'h0000_0600, 32'h0200_0C00};

  logic [IW-1:0]        widx;
  logic                 aligned, wr;
  int                   wk;
  logic                 stat, mask;
  logic [4:0]           core_q, core_nv;
  logic [N_PER-1:0]     per_q;
  logic [N_LINK:0]      per_tog;
  logic [N_CLK*32-1:0]  clk_flat;
  logic [31:0]          rd_val;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr      = bus_valid && bus_write && aligned;
  assign wk      = int'(widx);
  assign core_nv = bus_wdata[4:0] & CORE_WMASK;

  // interrupt group
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= 1'b0;
      mask <= 1'b1;
    end else begin
      stat <= irq_src | (stat & ~(wr && wk == IX_STAT && bus_wdata[0]));
      if (wr && wk == IX_EN && bus_wdata[0])
        mask <= 1'b0;
      else if (wr && wk == IX_DIS && bus_wdata[0])
        mask <= 1'b1;
    end
  end

  assign irq_o = stat & ~mask;

  // clock-control storage
  for (genvar k = 0; k < N_CLK; k++) begin : g_clk
    logic [31:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= CLK_INIT[k];
      else if (wr && wk == CLK_BASE + k)
        q <= bus_wdata & CLK_WMASK;
    end
    assign clk_flat[k*32 +: 32] = q;
  end

  // core resets: edge to request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_q       <= CORE_WMASK;
      core_off_req <= '0;
      core_on_req  <= '0;
    end else if (wr && wk == IX_CORE) begin
      core_off_req <= ~core_q[1:0] & core_nv[1:0];
      core_on_req  <= core_q[1:0] & ~core_nv[1:0];
      core_q       <= core_nv;
    end else begin
      core_off_req <= '0;
      core_on_req  <= '0;
    end
  end

  assign core_rst = core_q[1:0];

  // peripheral resets: any change pulses the linked ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q   <= '1;
      per_tog <= '0;
    end else begin
      per_tog <= '0;
      for (int i = 0; i < N_PER; i++) begin
        if (wr && wk == PER_BASE + i) begin
          per_q[i] <= bus_wdata[0];
          if (i <= N_LINK && bus_wdata[0] != per_q[i])
            per_tog[i] <= 1'b1;
        end
      end
    end
  end

  assign per_rst      = per_q;
  assign per_cold_rst = per_tog[N_LINK-1:0];
  assign dma_rst      = {N_DMA{per_q[DMA_IX]}};
  assign dma_cold_rst = {N_DMA{per_tog[DMA_IX]}};

  // read path
  always_comb begin
    rd_val = '0;
    if (aligned) begin
      if (wk == IX_STAT)
        rd_val = {31'b0, stat};
      else if (wk == IX_MASK)
        rd_val = {31'b0, mask};
      else if (wk >= CLK_BASE && wk < CLK_BASE + N_CLK)
        rd_val = clk_flat[(wk - CLK_BASE)*32 +: 32];
      else if (wk == IX_CORE)
        rd_val = {27'b0, core_q};
      else if (wk >= PER_BASE && wk < PER_BASE + N_PER)
        rd_val = {31'b0, per_q[wk - PER_BASE]};
    end
  end

  assign bus_rdata = (bus_valid && !bus_write) ? rd_val : 32'b0;

  AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wk == IX_EN && bus_wdata[0] && stat) |=> irq_o); // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_src |=> stat); // R3
  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wk == IX_STAT && bus_wdata[0] && !irq_src) |=> !stat); // R3
  AST_MASK_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wk == IX_MASK) |=> $stable(mask)); // R4
  AST_DIS_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wk == IX_DIS && bus_wdata[0]) |=> !irq_o); // R4
  AST_CORE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    core_off_req == (core_rst & ~$past(core_rst))); // R5
  AST_CORE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    core_on_req == (~core_rst & $past(core_rst))); // R5
  AST_PER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    per_cold_rst == (per_rst[N_LINK-1:0] ^ $past(per_rst[N_LINK-1:0]))); // R6
  AST_DMA_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_cold_rst == {N_DMA{dma_rst[0] ^ $past(dma_rst[0])}}); // R7
  AST_MISALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && !aligned) |=>
      ($stable(per_q) && $stable(core_q) && $stable(mask) && $stable(clk_flat))); // R9
  AST_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wk >= PER_BASE + N_PER) |=>
      ($stable(per_q) && $stable(core_q) && $stable(mask) && $stable(clk_flat))); // R9

endmodule

// File: tb/tb_lpd_rstctl_regs.sv
module tb_lpd_rstctl_regs;
  localparam int ADDR_W = 8;
  localparam int N_DMA  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0, irq_src = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_o;
  logic [1:0] core_rst, core_off_req, core_on_req;
  logic [14:0] per_rst;
  logic [4:0] per_cold_rst;
  logic [N_DMA-1:0] dma_rst, dma_cold_rst;

  int nvec = 0;
  int nfail = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  lpd_rstctl_regs #(.ADDR_W(ADDR_W), .N_DMA(N_DMA)) dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_src(irq_src), .irq_o(irq_o), .core_rst(core_rst),
    .core_off_req(core_off_req), .core_on_req(core_on_req),
    .per_rst(per_rst), .per_cold_rst(per_cold_rst),
    .dma_rst(dma_rst), .dma_cold_rst(dma_cold_rst));

  // {write?, waddr, wdata, raddr, expected read, requirement}
  localparam int NV = 19;
  localparam logic [88:0] VEC [NV] = '{
    {1'b0, 8'h00, 32'h0,          8'h04, 32'h0000_0001, 8'd1},  // R1 mask
    {1'b0, 8'h00, 32'h0,          8'h00, 32'h0000_0000, 8'd1},  // R1 status
    {1'b0, 8'h00, 32'h0,          8'h40, 32'h0000_0017, 8'd1},  // R1 core
    {1'b0, 8'h00, 32'h0,          8'h44, 32'h0000_0001, 8'd1},  // R1 periph
    {1'b0, 8'h00, 32'h0,          8'h10, 32'h0200_0300, 8'd1},  // R1 clock 0
    {1'b0, 8'h00, 32'h0,          8'h24, 32'h0200_0C00, 8'd1},  // R1 clock 5
    {1'b1, 8'h04, 32'h0,          8'h04, 32'h0000_0001, 8'd4},  // R4 mask ro
    {1'b1, 8'h08, 32'h1,          8'h04, 32'h0000_0000, 8'd4},  // R4 enable
    {1'b0, 8'h00, 32'h0,          8'h08, 32'h0000_0000, 8'd4},  // R4 alias reads 0
    {1'b1, 8'h0C, 32'hFFFF_FFFE,  8'h04, 32'h0000_0000, 8'd4},  // R4 bit0 only
    {1'b1, 8'h0C, 32'h1,          8'h0C, 32'h0000_0000, 8'd4},  // R4 alias reads 0
    {1'b0, 8'h00, 32'h0,          8'h04, 32'h0000_0001, 8'd4},  // R4 disable
    {1'b1, 8'h10, 32'hFFFF_FFFF,  8'h10, 32'h0203_FF07, 8'd8},  // R8
    {1'b1, 8'h14, 32'h1234_5678,  8'h14, 32'h0200_5600, 8'd8},  // R8
    {1'b1, 8'h80, 32'hFFFF_FFFF,  8'h80, 32'h0000_0000, 8'd9},  // R9 unmapped
    {1'b1, 8'h46, 32'h0,          8'h44, 32'h0000_0001, 8'd9},  // R9 misaligned
    {1'b0, 8'h00, 32'h0,          8'h42, 32'h0000_0000, 8'd9},  // R9 misaligned read
    {1'b1, 8'h40, 32'hFFFF_FFFF,  8'h40, 32'h0000_0017, 8'd5},  // R5 reserved
    {1'b1, 8'h7C, 32'h0,          8'h7C, 32'h0000_0000, 8'd6}   // R6 watchdog
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1 per_rst", {17'b0, per_rst}, 32'h7FFF);
    check("R1 dma_rst", {24'b0, dma_rst}, 32'hFF);
    check("R1 core_rst", {30'b0, core_rst}, 32'h3);
    check("R1 pulses", {16'b0, dma_cold_rst, per_cold_rst, core_off_req, core_on_req}, 32'h0);
    check("R10 idle rdata", bus_rdata, 32'h0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][88]) do_write(VEC[v][87:80], VEC[v][79:48]);
      do_read(VEC[v][47:40], rv);
      check($sformatf("R%0d vector %0d", VEC[v][7:0], v), rv, VEC[v][39:8]);
    end
    do_write(8'h7C, 32'h1);

    // interrupt, R2 and R3
    @(negedge clk); irq_src = 1'b1;
    @(negedge clk); irq_src = 1'b0;
    do_read(8'h00, rv); check("R3 set", rv, 32'h1);
    check("R2 masked", {31'b0, irq_o}, 32'h0);
    do_write(8'h08, 32'h1);
    check("R2 unmasked", {31'b0, irq_o}, 32'h1);
    do_write(8'h00, 32'h0);
    do_read(8'h00, rv); check("R3 write 0 keeps", rv, 32'h1);
    irq_src = 1'b1;
    do_write(8'h00, 32'h1);
    irq_src = 1'b0;
    do_read(8'h00, rv); check("R3 set wins", rv, 32'h1);
    do_write(8'h00, 32'h1);
    check("R3 cleared irq", {31'b0, irq_o}, 32'h0);
    do_read(8'h00, rv); check("R3 cleared", rv, 32'h0);
    @(negedge clk); irq_src = 1'b1;
    @(negedge clk); irq_src = 1'b0;
    check("R2 raised", {31'b0, irq_o}, 32'h1);
    do_write(8'h0C, 32'h1);
    check("R4 disable drops irq", {31'b0, irq_o}, 32'h0);
    do_write(8'h00, 32'h1);

    // core resets, R5
    do_write(8'h40, 32'h16);
    check("R5 release core0", {30'b0, core_on_req}, 32'h1);
    check("R5 no off", {30'b0, core_off_req}, 32'h0);
    check("R5 level", {30'b0, core_rst}, 32'h2);
    @(negedge clk);
    check("R5 one cycle", {28'b0, core_on_req, core_off_req}, 32'h0);
    do_write(8'h40, 32'h16);
    check("R5 unchanged", {28'b0, core_on_req, core_off_req}, 32'h0);
    do_write(8'h40, 32'h17);
    check("R5 power off core0", {28'b0, core_on_req, core_off_req}, 32'h1);
    do_write(8'h40, 32'h14);
    check("R5 release both", {28'b0, core_on_req, core_off_req}, 32'hC);

    // peripheral resets, R6 and R7
    do_write(8'h44, 32'h0);
    check("R6 uart0 pulse", {27'b0, per_cold_rst}, 32'h1);
    check("R6 uart0 level", {31'b0, per_rst[0]}, 32'h0);
    @(negedge clk);
    check("R6 one cycle", {27'b0, per_cold_rst}, 32'h0);
    do_write(8'h44, 32'h0);
    check("R6 same value", {27'b0, per_cold_rst}, 32'h0);
    do_write(8'h54, 32'h0);
    check("R6 usb pulse", {27'b0, per_cold_rst}, 32'h10);
    do_write(8'h44, 32'h1);
    check("R6 uart0 rising", {27'b0, per_cold_rst}, 32'h1);
    do_write(8'h5C, 32'h0);
    check("R6 spi0 level", {31'b0, per_rst[6]}, 32'h0);
    check("R6 spi0 no pulse", {16'b0, dma_cold_rst, per_cold_rst, 3'b0}, 32'h0);
    do_write(8'h58, 32'h0);
    check("R7 dma level", {24'b0, dma_rst}, 32'h0);
    check("R7 dma pulse", {24'b0, dma_cold_rst}, 32'hFF);
    @(negedge clk);
    check("R7 one cycle", {24'b0, dma_cold_rst}, 32'h0);
    do_write(8'h58, 32'h1);
    check("R7 dma release pulse", {24'b0, dma_cold_rst}, 32'hFF);
    check("R7 dma held", {24'b0, dma_rst}, 32'hFF);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule